// File: doc/BRIEF.md
# NAND Read Command and Address Sequencer

This block models the device side of a byte-wide NAND flash port that supports only reads. A host selects one of two chips with active-low chip enables. It writes command bytes and address bytes by pulling an active-low write strobe low while a command-latch or address-latch qualifier is high. It then pulls an active-low read strobe repeatedly to stream bytes out. Every strobe, qualifier and data bit passes through a two-flop synchroniser. Actions are taken on the synchronised falling edge of the strobe.

Each chip keeps its own mode, address-cycle count and byte address. Three read modes preset the column offset to 0, 256 or 512. Pages are 528 bytes wide, so row bytes are scaled by 528 rather than by a power of two. Memory contents come from a fixed function of the address, and everything at or above a fill limit reads as erased. Protocol misuse raises a sticky error flag and the block keeps running.

Top module: `nand_rd_seq`

## Requirements
- R1: Command 0x00 enters read mode 1 (column offset 0), 0x01 enters mode 2 (offset 0x100), 0x50 enters mode 3 (offset 0x200), and each restarts the address cycle count. Command 0xFF returns the chip to the idle state.
- R2: In a read mode, the first address byte b sets the address to b OR the mode offset. The second adds b*528*256, and the third adds b*528.
- R3: Each synchronised falling read strobe on the selected chip loads data_o with the byte at the current address and then increments that address by one. data_o holds the new byte no later than three clock edges after the strobe falls.
- R4: The byte at address a is (a[7:0] XOR a[15:8] XOR a[23:16]), further XORed with 0x5A for chip 2, when a < FILL_LIMIT. Otherwise it is 0xFF.
- R5: Chip enable 1 wins when both enables are low. With both high, strobes are ignored, rdy_o is 0 and data_oe_o stays 0.
- R6: rdy_o[i] is 1 only while chip i is selected and both strobes are high. data_oe_o is 1 only while a chip is selected and the read strobe is low. rdy_o[0] is chip 1.
- R7: Command latch takes priority over address latch. Neither is accepted except on a falling write strobe.
- R8: An address byte in the idle state, a fourth address byte, or an unknown command sets err_o. The offending byte leaves the address and mode unchanged, and err_o stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce1_ni | input | 1 | Chip enable 1, active low, higher priority |
| ce2_ni | input | 1 | Chip enable 2, active low |
| cle_i | input | 1 | Command latch qualifier |
| ale_i | input | 1 | Address latch qualifier |
| re_ni | input | 1 | Read strobe, active low |
| we_ni | input | 1 | Write strobe, active low |
| data_i | input | 8 | Command and address byte from host |
| data_o | output | 8 | Last byte read |
| data_oe_o | output | 1 | Data bus drive enable |
| rdy_o | output | 2 | Per-chip ready |
| err_o | output | 1 | Sticky protocol error |

## Verification
The bench uses the default parameters: 528-byte pages, a 26-bit address and a fill limit of 2112 bytes, which is four pages. With that limit, a third-cycle row byte of 3 combined with a mode-3 column lands on the last patterned byte, so a single read then crosses into erased memory. A nonzero second-cycle byte jumps far past the limit and shows the erased value directly. The column bytes are small, so the XOR pattern gives a distinct value at each address tested, and an offset or scaling fault changes the byte read.

// File: rtl/nand_rd_pkg.sv
package nand_rd_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RD1, ST_RD2, ST_RD3} rd_state_e;

  localparam logic [7:0] CMD_IDLE = 8'hFF;
  localparam logic [7:0] CMD_RD1  = 8'h00;
  localparam logic [7:0] CMD_RD2  = 8'h01;
  localparam logic [7:0] CMD_RD3  = 8'h50;

  function automatic logic [7:0] fill_byte(input logic [31:0] a, input logic chip,
                                           input logic [31:0] limit);
    if (a >= limit) return 8'hFF;
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ (chip ? 8'h5A : 8'h00);
  endfunction
endpackage

// File: rtl/nand_rd_sync.sv
module nand_rd_sync #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/nand_rd_chip.sv
module nand_rd_chip
  import nand_rd_pkg::*;
#(
  parameter int PAGE_BYTES = 528,
  parameter int ADDR_W     = 26
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              cmd_i,
  input  logic              adr_i,
  input  logic              rd_i,
  input  logic [7:0]        byte_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              err_o
);
  localparam logic [ADDR_W-1:0] ROW_LO_STEP = ADDR_W'(PAGE_BYTES);
  localparam logic [ADDR_W-1:0] ROW_HI_STEP = ADDR_W'(PAGE_BYTES * 256);

  rd_state_e         st_q;
  logic [1:0]        cyc_q;
  logic [ADDR_W-1:0] addr_q;
  logic              err_q;
  logic [ADDR_W-1:0] off;

  always_comb begin
    case (st_q)
      ST_RD2:  off = ADDR_W'(12'h100);
      ST_RD3:  off = ADDR_W'(12'h200);
      default: off = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cyc_q  <= '0;
      addr_q <= '0;
      err_q  <= 1'b0;
    end else if (sel_i && cmd_i) begin
      case (byte_i)
        CMD_IDLE: begin st_q <= ST_IDLE; cyc_q <= '0; end
        CMD_RD1:  begin st_q <= ST_RD1;  cyc_q <= '0; end
        CMD_RD2:  begin st_q <= ST_RD2;  cyc_q <= '0; end
        CMD_RD3:  begin st_q <= ST_RD3;  cyc_q <= '0; end
        default:  err_q <= 1'b1;
      endcase
    end else if (sel_i && adr_i) begin
      if (st_q == ST_IDLE || cyc_q == 2'd3) begin
        err_q <= 1'b1;
      end else begin
        cyc_q <= cyc_q + 2'd1;
        case (cyc_q)
          2'd0:    addr_q <= ADDR_W'(byte_i) | off;
          2'd1:    addr_q <= addr_q + ADDR_W'(byte_i) * ROW_HI_STEP;
          default: addr_q <= addr_q + ADDR_W'(byte_i) * ROW_LO_STEP;
        endcase
      end
    end else if (sel_i && rd_i) begin
      addr_q <= addr_q + 1'b1;
    end
  end

  assign addr_o = addr_q;
  assign err_o  = err_q;

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q); // R8
  AST_CYC_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd3 && sel_i && adr_i && !cmd_i) |=> (cyc_q == 2'd3 && $stable(addr_q))); // R8
  AST_READ_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && rd_i && !cmd_i && !adr_i) |=> addr_q == $past(addr_q) + 1'b1); // R3
  AST_IDLE_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && cmd_i && byte_i == CMD_IDLE) |=> (st_q == ST_IDLE && cyc_q == 2'd0)); // R1
endmodule

// File: rtl/nand_rd_seq.sv
module nand_rd_seq
  import nand_rd_pkg::*;
#(
  parameter int PAGE_BYTES = 528,
  parameter int ADDR_W     = 26,
  parameter int FILL_LIMIT = 2112
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ce1_ni,
  input  logic       ce2_ni,
  input  logic       cle_i,
  input  logic       ale_i,
  input  logic       re_ni,
  input  logic       we_ni,
  input  logic [7:0] data_i,
  output logic [7:0] data_o,
  output logic       data_oe_o,
  output logic [1:0] rdy_o,
  output logic       err_o
);
  localparam int NCHIP = 2;
  localparam int SW    = 14;

  logic [SW-1:0] raw, syn;
  logic          ce1_s, ce2_s, cle_s, ale_s, re_s, we_s;
  logic [7:0]    byte_s;
  logic          re_d_q, we_d_q;
  logic          we_fall, re_fall, sel_vld, sel_id;
  logic [ADDR_W-1:0] addr_w [NCHIP];
  logic [NCHIP-1:0]  err_w;
  logic [7:0]        data_q;

  assign raw = {data_i, ce1_ni, ce2_ni, cle_i, ale_i, re_ni, we_ni};

  nand_rd_sync #(.W(SW), .RST_VAL(14'b00000000_11_00_11)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw), .q_o(syn));

  assign {byte_s, ce1_s, ce2_s, cle_s, ale_s, re_s, we_s} = syn;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      re_d_q <= 1'b1;
      we_d_q <= 1'b1;
    end else begin
      re_d_q <= re_s;
      we_d_q <= we_s;
    end
  end

  assign we_fall = we_d_q && !we_s;
  assign re_fall = re_d_q && !re_s;
  assign sel_vld = !ce1_s || !ce2_s;
  assign sel_id  = ce1_s;  // chip 2 only when chip 1 not enabled

  for (genvar g = 0; g < NCHIP; g++) begin : g_chip
    nand_rd_chip #(.PAGE_BYTES(PAGE_BYTES), .ADDR_W(ADDR_W)) u_chip (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .sel_i (sel_vld && (sel_id == 1'(g))),
      .cmd_i (we_fall && cle_s),
      .adr_i (we_fall && !cle_s && ale_s),
      .rd_i  (re_fall),
      .byte_i(byte_s),
      .addr_o(addr_w[g]),
      .err_o (err_w[g])
    );
    assign rdy_o[g] = sel_vld && (sel_id == 1'(g)) && re_s && we_s;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_q <= '0;
    else if (sel_vld && re_fall && !(we_fall && (cle_s || ale_s)))
      data_q <= fill_byte(32'(addr_w[sel_id]), sel_id, 32'(FILL_LIMIT));
  end

  assign data_o    = data_q;
  assign data_oe_o = sel_vld && !re_s;
  assign err_o     = |err_w;

  AST_RDY_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rdy_o)); // R5
  AST_OE_NOT_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> rdy_o == 2'b00); // R6
  AST_NO_SEL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_vld) |=> $stable(data_q)); // R5
endmodule

// File: tb/nand_rd_seq_tb_top.sv
module nand_rd_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ce1_n = 1, ce2_n = 1, cle = 0, ale = 0, re_n = 1, we_n = 1;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic oe, err;
  logic [1:0] rdy;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  nand_rd_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ce1_ni(ce1_n), .ce2_ni(ce2_n), .cle_i(cle),
    .ale_i(ale), .re_ni(re_n), .we_ni(we_n), .data_i(din), .data_o(dout),
    .data_oe_o(oe), .rdy_o(rdy), .err_o(err));

  function automatic logic [7:0] model(input int a, input int chip);
    int v;
    if (a >= 2112) return 8'hFF;
    v = (a % 256) ^ ((a / 256) % 256) ^ ((a / 65536) % 256);
    if (chip == 2) v = v ^ 'h5A;
    return 8'(v);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    ce1_n = 1; ce2_n = 1; cle = 0; ale = 0; re_n = 1; we_n = 1; din = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic c, input logic a, input logic [7:0] d);
    cle = c; ale = a; din = d;
    repeat (3) @(negedge clk);
    we_n = 0;
    repeat (4) @(negedge clk);
    we_n = 1;
    repeat (4) @(negedge clk);
    cle = 0; ale = 0;
  endtask

  task automatic cmd(input logic [7:0] d); wr(1, 0, d); endtask
  task automatic adr(input logic [7:0] d); wr(0, 1, d); endtask

  task automatic rd(output logic [7:0] d, output logic e);
    re_n = 0;
    repeat (5) @(negedge clk);
    d = dout; e = oe;
    re_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R6 reset rdy", rdy, 0);
    check("R6 reset oe", oe, 0);
    check("R8 reset err", err, 0);
    check("R3 reset data", dout, 0);
  endtask

  task automatic t_modes();
    logic [7:0] d; logic e;
    do_reset();
    ce1_n = 0; repeat (4) @(negedge clk);
    check("R6 chip1 ready", rdy, 2'b01);
    cmd(8'h00); adr(8'h34); adr(8'h00); adr(8'h01);
    rd(d, e); check("R2 mode1 byte", d, model(528 + 'h34, 1));
    check("R6 oe while reading", e, 1);
    rd(d, e); check("R3 increment", d, model(528 + 'h35, 1));
    cmd(8'h01); adr(8'h05); adr(8'h00); adr(8'h00);
    rd(d, e); check("R1 mode2 offset", d, model('h105, 1));
    cmd(8'h50); adr(8'h05); adr(8'h00); adr(8'h00);
    rd(d, e); check("R1 mode3 offset", d, model('h205, 1));
    cmd(8'h00); adr(8'h00); adr(8'h01); adr(8'h00);
    rd(d, e); check("R2 second cycle scale", d, 8'hFF);
    check("R8 no err on legal use", err, 0);
  endtask

  task automatic t_fill_edge();
    logic [7:0] d; logic e;
    do_reset();
    ce1_n = 0;
    cmd(8'h50); adr(8'h0F); adr(8'h00); adr(8'h03);
    rd(d, e); check("R4 last filled", d, model(2111, 1));
    rd(d, e); check("R4 erased", d, 8'hFF);
  endtask

  task automatic t_select();
    logic [7:0] d; logic e;
    do_reset();
    ce1_n = 0;
    cmd(8'h00); adr(8'h40); adr(8'h00); adr(8'h00);
    ce1_n = 1; ce2_n = 0; repeat (4) @(negedge clk);
    check("R6 chip2 ready", rdy, 2'b10);
    cmd(8'h00); adr(8'h03); adr(8'h00); adr(8'h00);
    rd(d, e); check("R4 chip2 pattern", d, model(3, 2));
    ce1_n = 0; repeat (4) @(negedge clk);
    check("R5 both low picks chip1", rdy, 2'b01);
    rd(d, e); check("R5 chip1 priority read", d, model('h40, 1));
    ce1_n = 1; ce2_n = 1; repeat (4) @(negedge clk);
    check("R5 none ready", rdy, 0);
    cmd(8'h50); adr(8'h07);
    rd(d, e); check("R5 deselected oe", e, 0);
    check("R5 deselected data held", d, model('h40, 1));
    ce1_n = 0;
    rd(d, e); check("R5 ignored bus", d, model('h41, 1));
    check("R8 ignored no err", err, 0);
  endtask

  task automatic t_latch_prio();
    logic [7:0] d; logic e;
    do_reset();
    ce1_n = 0;
    wr(1, 1, 8'h01);
    adr(8'h05); adr(8'h00); adr(8'h00);
    check("R7 cle over ale no err", err, 0);
    rd(d, e); check("R7 cle over ale", d, model('h105, 1));
    cmd(8'h00);
    cle = 1; din = 8'h50;
    rd(d, e);
    cle = 0;
    adr(8'h05); adr(8'h00); adr(8'h00);
    rd(d, e); check("R7 cle needs write strobe", d, model('h005, 1));
  endtask

  task automatic t_errors();
    logic [7:0] d; logic e;
    do_reset(); ce1_n = 0;
    adr(8'h11);
    check("R8 addr in idle", err, 1);
    cmd(8'h00); adr(8'h02);
    check("R8 sticky", err, 1);
    do_reset(); ce1_n = 0;
    cmd(8'h00); cmd(8'hFF); adr(8'h01);
    check("R1 reset cmd to idle", err, 1);
    do_reset(); ce1_n = 0;
    cmd(8'h00); adr(8'h10); adr(8'h00); adr(8'h00); adr(8'h33);
    check("R8 fourth cycle", err, 1);
    rd(d, e); check("R8 fourth cycle ignored", d, model('h10, 1));
    do_reset(); ce1_n = 0;
    cmd(8'h50); cmd(8'h42);
    check("R8 unknown cmd", err, 1);
    adr(8'h05); adr(8'h00); adr(8'h00);
    rd(d, e); check("R8 mode kept", d, model('h205, 1));
  endtask

  initial begin
    t_reset_state();
    t_modes();
    t_fill_edge();
    t_select();
    t_latch_prio();
    t_errors();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule